// File: doc/BRIEF.md
# Byte-Access 16-bit Timer Register Bank

This block holds a 16-bit up/down counter, a 16-bit compare value and a 16-bit capture value. A CPU with an 8-bit data path reaches all three through a small byte-addressed window. Each 16-bit quantity spans two byte addresses, so the block keeps a single shared staging byte. This makes each two-byte transfer behave as one indivisible access. Writes stage the upper byte first, and the lower-byte write commits both halves in one clock edge. Reads work the other way round: reading a lower byte freezes the matching upper byte in the staging byte, and the upper-byte read returns that frozen value.

The counter advances on each cycle in which the selected timer clock enable is high. A direction input picks up-counting or down-counting. The block compares the count with the compare value on every cycle. It drives an equality output and keeps a sticky match flag, which software clears by writing a one to it. A capture strobe copies the live count into the capture value. The capture value can only be read from the bus.

Top module: `tmr16_bank`

## Requirements
- R1: While reset is low, every bus address 0 to 7 reads back 0x00, the sticky flag is 0, and the equality output is 1, because count and compare value are both zero.
- R2: A write to address 3 (compare upper byte) places the data byte in the staging byte and leaves the compare value unchanged.
- R3: A write to address 2 (compare lower byte) loads the compare value with the staging byte as bits 15:8 and the data byte as bits 7:0, both in the same clock edge.
- R4: A write to address 1 (count upper byte) goes only to the staging byte. A write to address 0 (count lower byte) loads the count with {staging byte, data byte} in that edge, even when the timer enable is high. Counting resumes on the next enabled cycle.
- R5: On each clock edge with the timer enable high and no count preset, the count becomes count+1 modulo 65536 when the direction input is 0, and count-1 modulo 65536 when it is 1. With the enable low, the count holds.
- R6: Reading address 0 returns count bits 7:0 and copies count bits 15:8 into the staging byte at that edge. Reading address 1 returns the staging byte.
- R7: A capture strobe copies the count into the capture value. Reading address 4 returns capture bits 7:0 and copies capture bits 15:8 into the staging byte. Reading address 5 returns the staging byte.
- R8: Writes to addresses 4 and 5 change neither the capture value nor the staging byte.
- R9: The equality output is 1 exactly when the count equals the compare value. The sticky flag (status address 6, bit 0) becomes 1 on the edge after any cycle with equality.
- R10: Writing a byte with bit 0 set to address 6 clears the sticky flag unless equality holds in that cycle, in which case the flag stays set. Writing bit 0 as zero leaves the flag as it is.
- R11: An upper-byte read (address 1 or 5) that follows no lower-byte read returns whatever the shared staging byte last received, including a byte staged for the compare register.
- R12: Addresses 2 and 3 read back compare bits 7:0 and 15:8 directly, with no effect on the staging byte. Address 7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Byte address in the register window |
| wdata_i | input | 8 | Write data byte |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe; its side effects take place at the clock edge |
| rdata_o | output | 8 | Read data byte, combinational from addr_i |
| tick_i | input | 1 | Selected timer clock enable |
| down_i | input | 1 | Count direction, 1 means down |
| cap_i | input | 1 | Capture strobe |
| match_o | output | 1 | Count equals compare value, this cycle |
| flag_o | output | 1 | Sticky compare-match flag |

## Verification
A corrupted staging byte is visible at the very next upper-byte read. The bench therefore reads every 16-bit value as a lower-then-upper pair, and it also reads upper bytes deliberately without a preceding lower read. A count that steps wrongly, or fails to hold on a preset, shows up after a short run of enabled cycles from preset values at the wrap points in both directions. A flag that fails to set, or clears when it should not, shows on the status read one cycle after the event.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int unsigned BYTE_W = 8;

  // register window; lower byte of each pair sits one below its upper byte
  localparam int unsigned A_CNT_LO = 0;
  localparam int unsigned A_CNT_HI = 1;
  localparam int unsigned A_CMP_LO = 2;
  localparam int unsigned A_CMP_HI = 3;
  localparam int unsigned A_CAP_LO = 4;
  localparam int unsigned A_CAP_HI = 5;
  localparam int unsigned A_STS    = 6;

  typedef struct packed {
    logic cnt_lo_wr;
    logic cnt_hi_wr;
    logic cmp_lo_wr;
    logic cmp_hi_wr;
    logic sts_wr;
    logic cnt_lo_rd;
    logic cap_lo_rd;
  } acc_s;
endpackage

// File: rtl/tmr16_decode.sv
module tmr16_decode #(
  parameter int unsigned ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output tmr16_pkg::acc_s   acc_o
);
  import tmr16_pkg::*;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned k);
    return a == ADDR_W'(k);
  endfunction

  always_comb begin
    acc_o           = '0;
    acc_o.cnt_lo_wr = wr_i && hit(addr_i, A_CNT_LO);
    acc_o.cnt_hi_wr = wr_i && hit(addr_i, A_CNT_HI);
    acc_o.cmp_lo_wr = wr_i && hit(addr_i, A_CMP_LO);
    acc_o.cmp_hi_wr = wr_i && hit(addr_i, A_CMP_HI);
    acc_o.sts_wr    = wr_i && hit(addr_i, A_STS);
    acc_o.cnt_lo_rd = rd_i && hit(addr_i, A_CNT_LO);
    acc_o.cap_lo_rd = rd_i && hit(addr_i, A_CAP_LO);
  end
endmodule

// File: rtl/tmr16_temp.sv
module tmr16_temp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tmr16_pkg::acc_s   acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_hi_i,
  input  logic [DATA_W-1:0] cap_hi_i,
  output logic [DATA_W-1:0] tmp_o
);
  // bus writes win over read-side latching in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             tmp_o <= '0;
    else if (acc_i.cnt_hi_wr || acc_i.cmp_hi_wr) tmp_o <= wdata_i;
    else if (acc_i.cnt_lo_rd)                tmp_o <= cnt_hi_i;
    else if (acc_i.cap_lo_rd)                tmp_o <= cap_hi_i;
  end
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             down_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (tick_i) cnt_o <= down_i ? cnt_o - ONE : cnt_o + ONE;
  end
endmodule

// File: rtl/tmr16_hold.sv
module tmr16_hold #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/tmr16_bank.sv
module tmr16_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic              down_i,
  input  logic              cap_i,
  output logic              match_o,
  output logic              flag_o
);
  import tmr16_pkg::*;

  localparam int unsigned CNT_W = 2 * DATA_W;

  acc_s              acc;
  logic [DATA_W-1:0] tmp_q;
  logic [CNT_W-1:0]  cnt_q, cmp_q, cap_q;
  logic              flag_q;

  tmr16_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i), .acc_o(acc)
  );

  tmr16_temp #(.DATA_W(DATA_W)) u_tmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .wdata_i(wdata_i),
    .cnt_hi_i(cnt_q[CNT_W-1:DATA_W]), .cap_hi_i(cap_q[CNT_W-1:DATA_W]),
    .tmp_o(tmp_q)
  );

  tmr16_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(acc.cnt_lo_wr),
    .load_val_i({tmp_q, wdata_i}), .tick_i(tick_i), .down_i(down_i),
    .cnt_o(cnt_q)
  );

  tmr16_hold #(.W(CNT_W)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(acc.cmp_lo_wr),
    .d_i({tmp_q, wdata_i}), .q_o(cmp_q)
  );

  tmr16_hold #(.W(CNT_W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cap_i), .d_i(cnt_q), .q_o(cap_q)
  );

  assign match_o = (cnt_q == cmp_q);

  // set has priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        flag_q <= 1'b0;
    else if (match_o)                   flag_q <= 1'b1;
    else if (acc.sts_wr && wdata_i[0])  flag_q <= 1'b0;
  end
  assign flag_o = flag_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_CNT_LO))      rdata_o = cnt_q[DATA_W-1:0];
    else if (addr_i == ADDR_W'(A_CNT_HI)) rdata_o = tmp_q;
    else if (addr_i == ADDR_W'(A_CMP_LO)) rdata_o = cmp_q[DATA_W-1:0];
    else if (addr_i == ADDR_W'(A_CMP_HI)) rdata_o = cmp_q[CNT_W-1:DATA_W];
    else if (addr_i == ADDR_W'(A_CAP_LO)) rdata_o = cap_q[DATA_W-1:0];
    else if (addr_i == ADDR_W'(A_CAP_HI)) rdata_o = tmp_q;
    else if (addr_i == ADDR_W'(A_STS))    rdata_o = DATA_W'(flag_q);
  end
endmodule

// File: rtl/tmr16_bank_chk.sv
module tmr16_bank_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic                tick_i,
  input logic                down_i,
  input logic                cap_i,
  input logic                match_o,
  input logic                flag_o,
  input logic [DATA_W-1:0]   tmp_q,
  input logic [2*DATA_W-1:0] cnt_q,
  input logic [2*DATA_W-1:0] cmp_q,
  input logic [2*DATA_W-1:0] cap_q
);
  localparam int unsigned CNT_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] K0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] K1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] K2 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] K3 = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] K6 = ADDR_W'(6);

  logic preset, stage_wr;
  assign preset   = wr_i && addr_i == K0;
  assign stage_wr = wr_i && (addr_i == K1 || addr_i == K3);

  assert_cmp_hi_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == K3 |=> $stable(cmp_q));

  assert_cmp_lo_commit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == K2 |=> cmp_q == {$past(tmp_q), $past(wdata_i)});

  assert_cnt_preset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset |=> cnt_q == {$past(tmp_q), $past(wdata_i)});

  assert_cnt_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !down_i && !preset |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  assert_cnt_down_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && down_i && !preset |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));

  assert_cnt_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !preset |=> $stable(cnt_q));

  assert_lo_read_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == K0 && !stage_wr |=> tmp_q == $past(cnt_q[CNT_W-1:DATA_W]));

  assert_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> cap_q == $past(cnt_q));

  assert_flag_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> flag_o);

  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !(wr_i && addr_i == K6 && wdata_i[0]) |=> flag_o);
endmodule

bind tmr16_bank tmr16_bank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_i(wr_i), .rd_i(rd_i), .tick_i(tick_i), .down_i(down_i), .cap_i(cap_i),
  .match_o(match_o), .flag_o(flag_o), .tmp_q(tmp_q), .cnt_q(cnt_q),
  .cmp_q(cmp_q), .cap_q(cap_q)
);

// File: tb/sim_tmr16_bank.sv
`timescale 1ns/1ps
module sim_tmr16_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0, tick = 1'b0, down = 1'b0, cap = 1'b0;
  logic [7:0] rdata;
  logic       match, flag;
  int         checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tmr16_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .rd_i(rd), .rdata_o(rdata), .tick_i(tick), .down_i(down), .cap_i(cap),
    .match_o(match), .flag_o(flag)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    bus_rd(lo, l);
    bus_rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic wr16(input logic [2:0] lo, input logic [15:0] v);
    bus_wr(lo + 3'd1, v[15:8]);
    bus_wr(lo, v[7:0]);
  endtask

  task automatic run_ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    logic [15:0] starts [4];
    starts = '{16'h0000, 16'h00FF, 16'hFFFE, 16'h8001};

    // R1: reset state
    #12;
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk("R1 read", {8'h00, rdata}, 16'h0000);
    end
    chk("R1 flag", {15'd0, flag}, 16'd0);
    chk("R1 match", {15'd0, match}, 16'd1);
    @(negedge clk); rst_n = 1'b1;

    // R2/R3/R12: compare staging and commit
    bus_wr(3'd3, 8'h12);
    rd16(3'd2, v);
    chk("R2 cmp unchanged", v, 16'h0000);
    bus_wr(3'd2, 8'h34);
    rd16(3'd2, v);
    chk("R3 cmp loaded", v, 16'h1234);
    bus_wr(3'd1, 8'h5A);
    bus_rd(3'd3, b);
    bus_rd(3'd1, b);
    chk("R12 cmp read leaves staging", {8'h00, b}, 16'h005A);
    bus_rd(3'd7, b);
    chk("R12 unused address", {8'h00, b}, 16'h0000);

    // R10: clear flag (set since reset while cnt==cmp==0)
    bus_rd(3'd6, b);
    chk("R9 flag set after reset equality", {8'h00, b}, 16'h0001);
    bus_wr(3'd6, 8'h01);
    bus_rd(3'd6, b);
    chk("R10 flag cleared", {8'h00, b}, 16'h0000);

    // R5/R6: counting sweep over wrap points, both directions
    for (int dn = 0; dn < 2; dn++) begin
      for (int s = 0; s < 4; s++) begin
        for (int k = 0; k < 6; k++) begin
          down = dn[0];
          wr16(3'd0, starts[s]);
          run_ticks(k);
          rd16(3'd0, v);
          chk(dn ? "R5 down count" : "R5 up count", v,
              dn ? 16'(starts[s] - 16'(k)) : 16'(starts[s] + 16'(k)));
        end
      end
    end
    down = 1'b0;

    // R4: preset wins over tick in same cycle, counting resumes after
    bus_wr(3'd1, 8'hC0);
    @(negedge clk); addr = 3'd0; wdata = 8'h10; wr = 1'b1; tick = 1'b1;
    @(negedge clk); wr = 1'b0;
    @(negedge clk); tick = 1'b0;
    rd16(3'd0, v);
    chk("R4 preset then one tick", v, 16'hC011);
    bus_wr(3'd1, 8'h77);
    rd16(3'd0, v);
    chk("R4 hi write alone leaves count", v, 16'hC011);

    // R6: latched upper byte stays coherent when count moves between reads
    wr16(3'd0, 16'h12FF);
    bus_rd(3'd0, b);
    chk("R6 low byte", {8'h00, b}, 16'h00FF);
    run_ticks(1);
    bus_rd(3'd1, b);
    chk("R6 latched high", {8'h00, b}, 16'h0012);

    // R11: upper-byte reads without a low read, shared staging byte
    bus_wr(3'd3, 8'hA5);
    bus_rd(3'd1, b);
    chk("R11 cnt hi shows cmp staging", {8'h00, b}, 16'h00A5);
    bus_rd(3'd5, b);
    chk("R11 cap hi shows cmp staging", {8'h00, b}, 16'h00A5);
    bus_wr(3'd2, 8'h34);
    bus_rd(3'd0, b);
    bus_wr(3'd3, 8'h3C);
    bus_rd(3'd1, b);
    chk("R11 interleave overwrites latch", {8'h00, b}, 16'h003C);
    rd16(3'd2, v);
    chk("R3 cmp after interleave", v, 16'hA534);
    wr16(3'd2, 16'h1234);

    // R7/R8: capture and read-only capture window
    wr16(3'd0, 16'hBEEF);
    @(negedge clk); cap = 1'b1;
    @(negedge clk); cap = 1'b0;
    wr16(3'd0, 16'h0101);
    rd16(3'd4, v);
    chk("R7 capture value", v, 16'hBEEF);
    bus_wr(3'd3, 8'h77);
    bus_wr(3'd5, 8'h11);
    bus_wr(3'd4, 8'h22);
    bus_rd(3'd1, b);
    chk("R8 staging untouched", {8'h00, b}, 16'h0077);
    rd16(3'd4, v);
    chk("R8 capture untouched", v, 16'hBEEF);
    wr16(3'd2, 16'h1234);

    // R9/R10: match flag behaviour
    wr16(3'd0, 16'h1230);
    bus_wr(3'd6, 8'h01);
    bus_rd(3'd6, b);
    chk("R10 flag clear before match", {8'h00, b}, 16'h0000);
    run_ticks(4);
    #1 chk("R9 equality output", {15'd0, match}, 16'd1);
    bus_rd(3'd6, b);
    chk("R9 flag set", {8'h00, b}, 16'h0001);
    bus_wr(3'd6, 8'h01);
    bus_rd(3'd6, b);
    chk("R10 set wins over clear", {8'h00, b}, 16'h0001);
    run_ticks(3);
    #1 chk("R9 equality drops", {15'd0, match}, 16'd0);
    bus_wr(3'd6, 8'hFE);
    bus_rd(3'd6, b);
    chk("R10 zero bit keeps flag", {8'h00, b}, 16'h0001);
    bus_wr(3'd6, 8'h01);
    #1 chk("R10 flag cleared port", {15'd0, flag}, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule